// File: doc/BRIEF.md
# Qualified Programmable Event Counter

This block counts hardware events with one programmable counter. Every cycle, an 8-bit event code picks one group of eight sub-event lines. An 8-bit unit mask then chooses which lines of that group are added into the cycle's event sum. A qualifier stage processes that sum before the counter register takes it. The stage gates the sum by privilege level. It can then turn the sum into a one-per-cycle condition by comparing it with a threshold, reverse that compare, and keep only the rising edges of the condition.

Software reaches the block through a small register port. The port can read and write the control word, the counter and a sticky overflow flag. When the counter wraps past its top value, the flag is set and an interrupt can be raised. A typical use is counting the cycles in which at least N events fire. Another is counting the number of busy episodes of a long busy signal instead of its busy cycles.

Top module: `qual_evt_counter`

## Requirements
- R1: Event lines are grouped so that group g occupies `evt_lines_i[8g+7:8g]`. Control bits [7:0] are the event code, which picks group g = code. A code at or above the number of groups selects nothing and adds 0. Control bits [15:8] are the unit mask. Each set mask bit k adds line k of the chosen group to the cycle sum, so a mask of FFh adds all eight lines.
- R2: With the threshold field (control bits [31:24]) at 0, each counting cycle adds the raw sum, and the invert and edge bits have no effect.
- R3: With a nonzero threshold, a counting cycle adds 1 when the sum is greater than or equal to the threshold, and adds 0 otherwise.
- R4: With a nonzero threshold and the invert bit (control bit 19) set, a counting cycle adds 1 when the sum is below the threshold.
- R5: With a nonzero threshold and the edge bit (control bit 18) set, the counter adds 1 only in a cycle where the qualified condition is true after a cycle where it was false. A condition that stays true for many cycles adds 1 in total.
- R6: Counting happens at privilege level 0 (`priv_i` = 0) only if the os bit (control bit 17) is set. It happens at levels 1 to 3 only if the usr bit (control bit 16) is set.
- R7: No counting occurs while the enable bit (control bit 22) is clear.
- R8: Register addresses are 0 for control, 1 for the counter and 2 for status. Reads are combinational. A counter write loads the value, and it wins over an increment in the same cycle.
- R9: When an increment carries out of the CNT_W-bit counter, the counter wraps and status bit 0 is set and stays set. `irq_o` follows that bit when the interrupt-enable bit (control bit 20) is set. Writing 1 to status bit 0 clears it, and writing 0 leaves it unchanged.
- R10: The edge history is cleared on any control write and while the counter is disabled. After a rewrite, a condition that is still true counts again.
- R11: After reset, the control word, the counter and the status bit read 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_lines_i | input | NUM_GROUPS*8 | Sub-event lines, eight per group |
| priv_i | input | 2 | Current privilege level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data |
| irq_o | output | 1 | Overflow interrupt |

## Verification
The bench targets the edges of the qualifier modes.

- A threshold compare written as strictly greater would lose the cycles whose sum equals the threshold. An invert bit that leaked into threshold-zero mode would change raw sums.
- An edge detector whose history survives a control rewrite would miss the fresh occurrence that follows.
- A counter write that lost to a same-cycle increment would read back one too high.
- A non-sticky or mis-cleared overflow flag would drop the interrupt right after the wrap, or clear it on a write of 0.
- An out-of-range event code that aliased onto a real group would count lines it must ignore.

// File: rtl/qec_pkg.sv
package qec_pkg;
  localparam int unsigned CTRL_W = 32;

  typedef struct packed {
    logic [7:0] thresh;   // 31:24
    logic       rsvd1;    // 23
    logic       enable;   // 22
    logic       rsvd0;    // 21
    logic       irq_en;   // 20
    logic       inv;      // 19
    logic       edge_en;  // 18
    logic       os_en;    // 17
    logic       usr_en;   // 16
    logic [7:0] umask;    // 15:8
    logic [7:0] code;     // 7:0
  } ctrl_t;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CNT  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
endpackage

// File: rtl/qec_select.sv
module qec_select #(
  parameter int unsigned NUM_GROUPS = 4
) (
  input  logic [NUM_GROUPS*8-1:0] lines_i,
  input  logic [7:0]              code_i,
  input  logic [7:0]              umask_i,
  output logic [3:0]              sum_o
);
  localparam int unsigned GSEL_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
  localparam logic [7:0]  NG8    = 8'(NUM_GROUPS);

  logic [7:0] grp [NUM_GROUPS];
  logic [7:0] picked;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp[g] = lines_i[g*8 +: 8];
  end

  always_comb begin
    picked = '0;
    if (code_i < NG8) picked = grp[code_i[GSEL_W-1:0]];
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < 8; k++) sum_o = sum_o + {3'b0, picked[k] & umask_i[k]};
  end
endmodule

// File: rtl/qec_qualify.sv
module qec_qualify
  import qec_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  ctrl_t      ctrl_i,
  input  logic       ctrl_wr_i,
  input  logic [1:0] priv_i,
  input  logic [3:0] sum_i,
  output logic [3:0] inc_o
);
  logic thr_zero, priv_ok, active, ge, cond, prev_q;

  assign thr_zero = (ctrl_i.thresh == 8'd0);
  assign priv_ok  = (priv_i == 2'd0) ? ctrl_i.os_en : ctrl_i.usr_en;
  assign active   = ctrl_i.enable & priv_ok;
  assign ge       = ({4'b0, sum_i} >= ctrl_i.thresh);
  assign cond     = !thr_zero && active && (ctrl_i.inv ? !ge : ge);

  always_comb begin
    if (!active)             inc_o = 4'd0;
    else if (thr_zero)       inc_o = sum_i;
    else if (ctrl_i.edge_en) inc_o = {3'b0, cond & ~prev_q};
    else                     inc_o = {3'b0, cond};
  end

  // history cleared on rewrite or disable so counting never starts on a stale level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         prev_q <= 1'b0;
    else if (ctrl_wr_i || !ctrl_i.enable) prev_q <= 1'b0;
    else                                 prev_q <= cond;
  end

  AST_THR_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.thresh != 8'd0) |-> (inc_o <= 4'd1)); // R3
  AST_INV_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.thresh != 8'd0 && ctrl_i.inv && {4'b0, sum_i} >= ctrl_i.thresh) |-> (inc_o == 4'd0)); // R4
  AST_EDGE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.edge_en && ctrl_i.thresh != 8'd0 && inc_o != 4'd0 && !ctrl_wr_i) |=> (inc_o == 4'd0)); // R5
endmodule

// File: rtl/qec_count.sv
module qec_count #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       inc_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W:0] nxt;
  logic           wrap;

  assign nxt  = {1'b0, cnt_o} + {{(CNT_W-3){1'b0}}, inc_i};
  assign wrap = !wr_i && nxt[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (wr_i) cnt_o <= wdata_i;
    else           cnt_o <= nxt[CNT_W-1:0];
  end

  // a new wrap outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_o <= 1'b0;
    else if (wrap)      ovf_o <= 1'b1;
    else if (ovf_clr_i) ovf_o <= 1'b0;
  end

  AST_WR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (cnt_o == $past(wdata_i))); // R8
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !ovf_clr_i) |=> ovf_o); // R9
endmodule

// File: rtl/qual_evt_counter.sv
module qual_evt_counter
  import qec_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = 4,
  parameter int unsigned CNT_W      = 48
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_GROUPS*8-1:0] evt_lines_i,
  input  logic [1:0]              priv_i,
  input  logic                    reg_we_i,
  input  logic [1:0]              reg_addr_i,
  input  logic [CNT_W-1:0]        reg_wdata_i,
  output logic [CNT_W-1:0]        reg_rdata_o,
  output logic                    irq_o
);
  ctrl_t            ctrl_q;
  logic             ctrl_wr, cnt_wr, stat_clr, ovf;
  logic [3:0]       sum, inc;
  logic [CNT_W-1:0] cnt;

  assign ctrl_wr  = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign cnt_wr   = reg_we_i && (reg_addr_i == ADDR_CNT);
  assign stat_clr = reg_we_i && (reg_addr_i == ADDR_STAT) && reg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ctrl_q <= '0;
    else if (ctrl_wr) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  qec_select #(.NUM_GROUPS(NUM_GROUPS)) u_select (
    .lines_i (evt_lines_i),
    .code_i  (ctrl_q.code),
    .umask_i (ctrl_q.umask),
    .sum_o   (sum)
  );

  qec_qualify u_qualify (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_i    (ctrl_q),
    .ctrl_wr_i (ctrl_wr),
    .priv_i    (priv_i),
    .sum_i     (sum),
    .inc_o     (inc)
  );

  qec_count #(.CNT_W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (inc),
    .wr_i      (cnt_wr),
    .wdata_i   (reg_wdata_i),
    .ovf_clr_i (stat_clr),
    .cnt_o     (cnt),
    .ovf_o     (ovf)
  );

  always_comb begin
    case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADDR_CNT:  reg_rdata_o = cnt;
      ADDR_STAT: reg_rdata_o = {{(CNT_W-1){1'b0}}, ovf};
      default:   reg_rdata_o = '0;
    endcase
  end

  assign irq_o = ovf & ctrl_q.irq_en;

  AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.enable && !cnt_wr) |=> $stable(cnt)); // R7
  AST_PRIV_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && ((priv_i == 2'd0 && !ctrl_q.os_en) || (priv_i != 2'd0 && !ctrl_q.usr_en)))
      |=> $stable(cnt)); // R6
  AST_OOR_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_wr && ctrl_q.thresh == 8'd0 && ctrl_q.code >= 8'(NUM_GROUPS)) |=> $stable(cnt)); // R1
endmodule

// File: tb/qual_evt_counter_bench.sv
module qual_evt_counter_bench;
  localparam int NG = 4;
  localparam int CW = 48;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NG*8-1:0] lines = '0;
  logic [1:0]    priv = 2'd3;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          irq;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  qual_evt_counter #(.NUM_GROUPS(NG), .CNT_W(CW)) u_qual_evt_counter (
    .clk_i(clk), .rst_ni(rst_n), .evt_lines_i(lines), .priv_i(priv),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [CW-1:0] mk(input logic [7:0] code, input logic [7:0] um,
      input logic usr, input logic os, input logic edg, input logic inv,
      input logic ie, input logic en, input logic [7:0] thr);
    return {16'b0, thr, 1'b0, en, 1'b0, ie, inv, edg, os, usr, um, code};
  endfunction

  task automatic chk(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CW-1:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic cyc(input logic [NG*8-1:0] l, input logic [1:0] p);
    lines = l; priv = p;
    @(negedge clk);
  endtask

  // counter preset while disabled, then enable
  task automatic start(input logic [CW-1:0] ctrl, input logic [CW-1:0] preset);
    wr(2'd1, preset);
    wr(2'd0, ctrl);
  endtask

  task automatic stop(input logic [NG*8-1:0] idle);
    lines = idle;
    wr(2'd0, '0);
  endtask

  task automatic t_reset;
    logic [CW-1:0] v;
    rd(2'd0, v); chk("R11 ctrl", v, '0);
    rd(2'd1, v); chk("R11 cnt", v, '0);
    rd(2'd2, v); chk("R11 stat", v, '0);
    chk("R11 irq", {47'b0, irq}, '0);
  endtask

  task automatic t_select;
    logic [CW-1:0] v;
    // thr 0 with inv and edge set: raw sums still added
    start(mk(8'd1, 8'h05, 1, 1, 1, 1, 0, 1, 8'd0), '0);
    cyc(32'h0000_FF00, 3); cyc(32'h0000_0100, 3); cyc(32'h0000_00FF, 3);
    cyc(32'h0000_0400, 3); cyc(32'h0000_0400, 3);
    stop('0);
    rd(2'd1, v); chk("R1 R2 umask sum, inv/edge ignored", v, 48'd5);
    start(mk(8'd1, 8'hFF, 1, 1, 0, 0, 0, 1, 8'd0), '0);
    cyc(32'h0000_F000, 3); cyc(32'h0000_FF00, 3);
    stop('0);
    rd(2'd1, v); chk("R1 full mask", v, 48'd12);
    start(mk(8'd5, 8'hFF, 1, 1, 0, 0, 0, 1, 8'd0), '0);
    cyc('1, 3); cyc('1, 3);
    stop('0);
    rd(2'd1, v); chk("R1 out of range code", v, 48'd0);
  endtask

  task automatic t_thresh;
    logic [CW-1:0] v;
    start(mk(8'd2, 8'hFF, 1, 1, 0, 0, 0, 1, 8'd3), '0);
    cyc(32'h0003_0000, 3); cyc(32'h0007_0000, 3); cyc(32'h001F_0000, 3); cyc('0, 3);
    stop('0);
    rd(2'd1, v); chk("R3 threshold ge", v, 48'd2);
  endtask

  task automatic t_invert;
    logic [CW-1:0] v;
    lines = 32'h00FF_0000;
    start(mk(8'd2, 8'hFF, 1, 1, 0, 1, 0, 1, 8'd3), '0);
    cyc(32'h0003_0000, 3); cyc(32'h0007_0000, 3); cyc(32'h001F_0000, 3);
    cyc('0, 3); cyc(32'h0001_0000, 3);
    stop(32'h00FF_0000);
    rd(2'd1, v); chk("R4 inverted below", v, 48'd3);
  endtask

  task automatic t_edge;
    logic [CW-1:0] v;
    start(mk(8'd3, 8'hFF, 1, 1, 1, 0, 0, 1, 8'd1), '0);
    cyc('0, 3); cyc(32'h0100_0000, 3); cyc(32'h0100_0000, 3); cyc(32'h0100_0000, 3);
    cyc('0, 3); cyc(32'h0300_0000, 3); cyc('0, 3);
    stop('0);
    rd(2'd1, v); chk("R5 busy episodes", v, 48'd2);
  endtask

  task automatic t_priv;
    logic [CW-1:0] v;
    start(mk(8'd0, 8'h01, 0, 1, 0, 0, 0, 1, 8'd0), '0);
    cyc(32'h1, 0); cyc(32'h1, 1); cyc(32'h1, 2); cyc(32'h1, 3); cyc(32'h1, 0);
    stop('0);
    rd(2'd1, v); chk("R6 os only", v, 48'd2);
    start(mk(8'd0, 8'h01, 1, 0, 0, 0, 0, 1, 8'd0), '0);
    cyc(32'h1, 0); cyc(32'h1, 3); cyc(32'h1, 1);
    stop('0);
    rd(2'd1, v); chk("R6 usr only", v, 48'd2);
  endtask

  task automatic t_enable;
    logic [CW-1:0] v;
    start(mk(8'd0, 8'hFF, 1, 1, 0, 0, 1, 0, 8'd0), 48'd7);
    cyc('1, 0); cyc('1, 3); cyc('1, 2);
    stop('0);
    rd(2'd1, v); chk("R7 disabled holds", v, 48'd7);
  endtask

  task automatic t_write;
    logic [CW-1:0] v;
    lines = 32'h1;
    start(mk(8'd0, 8'h01, 1, 1, 0, 0, 0, 1, 8'd0), '0);
    cyc(32'h1, 3);
    rd(2'd1, v); chk("R8 counting", v, 48'd1);
    wr(2'd1, 48'd100);
    rd(2'd1, v); chk("R8 write wins", v, 48'd100);
    cyc(32'h1, 3);
    rd(2'd1, v); chk("R8 resumes", v, 48'd101);
    stop('0);
  endtask

  task automatic t_ovf;
    logic [CW-1:0] v;
    lines = 32'h1;
    start(mk(8'd0, 8'h01, 1, 1, 0, 0, 1, 1, 8'd0), 48'hFFFF_FFFF_FFFE);
    cyc(32'h1, 3); cyc(32'h1, 3);
    stop('0);
    rd(2'd1, v); chk("R9 wrap value", v, 48'd0);
    rd(2'd2, v); chk("R9 status set", v, 48'd1);
    chk("R9 irq", {47'b0, irq}, 48'd0); // ctrl now disabled, irq_en cleared
    wr(2'd0, mk(8'd0, 8'h01, 1, 1, 0, 0, 1, 0, 8'd0));
    chk("R9 irq with enable", {47'b0, irq}, 48'd1);
    wr(2'd2, 48'd0);
    rd(2'd2, v); chk("R9 write 0 keeps", v, 48'd1);
    wr(2'd2, 48'd1);
    rd(2'd2, v); chk("R9 w1c", v, 48'd0);
    chk("R9 irq drops", {47'b0, irq}, 48'd0);
    lines = 32'h1;
    start(mk(8'd0, 8'h01, 1, 1, 0, 0, 0, 1, 8'd0), 48'hFFFF_FFFF_FFFF);
    cyc(32'h1, 3);
    stop('0);
    rd(2'd2, v); chk("R9 status no irq_en", v, 48'd1);
    chk("R9 irq masked", {47'b0, irq}, 48'd0);
    wr(2'd2, 48'd1);
  endtask

  task automatic t_edge_clear;
    logic [CW-1:0] v;
    logic [CW-1:0] c;
    c = mk(8'd0, 8'h01, 1, 1, 1, 0, 0, 1, 8'd1);
    lines = 32'h1;
    start(c, '0);
    cyc(32'h1, 3); cyc(32'h1, 3);
    wr(2'd0, c);
    cyc(32'h1, 3); cyc(32'h1, 3);
    rd(2'd1, v); chk("R10 rewrite recounts", v, 48'd2);
    wr(2'd0, '0);
    wr(2'd0, c);
    cyc(32'h1, 3);
    stop('0);
    rd(2'd1, v); chk("R10 reenable recounts", v, 48'd3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_select;
    t_thresh;
    t_invert;
    t_edge;
    t_priv;
    t_enable;
    t_write;
    t_ovf;
    t_edge_clear;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule